// File: doc/BRIEF.md
# Split Store Address/Data Queue

This block is a store queue in which each store reaches it as two independent operations. When the store is dispatched it takes an entry in program order. Its effective address is written into that entry as soon as address generation finishes, and its data is written later, whenever the data operand is ready. The address and data halves may arrive in either order or in the same cycle. An entry leaves the queue toward the cache only when both halves are present, and it leaves from the oldest end, one store per cycle.

Because the address is recorded before the data exists, a load can be checked for ordering hazards against older stores right away. A load probe names the queue position the load saw at its own dispatch and gives its address, compared at a 16-byte granule. The queue then reports one of four outcomes: no conflict, forward the data, stall until the data arrives, or an unresolved dependence on an older store whose address is still unknown. A flush discards every entry from a given position onward, which removes stores on a mispredicted path.

Each entry carries 128 data bits, so a paired store fits in one entry. The default depth is 36 entries.

Top module: `store_split_queue`

## Requirements
- R1: After reset the queue is empty: alloc_ready_o=1, alloc_ptr_o=0, drain_valid_o=0 and probe_status_o=0.
- R2: alloc_ptr_o is the position of the next allocation: the MSB is a phase bit and the low bits are an index that counts 0..DEPTH-1, wraps to 0 and toggles the phase on the wrap. An accepted allocation (alloc_valid_i and alloc_ready_o) advances it by one, and the new entry has neither half present.
- R3: alloc_ready_o is 0 while DEPTH entries are held or flush_i is high. alloc_valid_i then has no effect, and alloc_ptr_o stays unchanged.
- R4: An address write (addr_valid_i, addr_idx_i) and a data write (data_valid_i, data_idx_i) fill the held entry at that index independently, in either order or in the same cycle. An entry counts as complete only once both halves have been written.
- R5: drain_valid_o is high exactly when the oldest held entry is complete and flush_i is low, with that entry's address and data on drain_addr_o and drain_data_o. drain_ready_i removes it, so stores leave oldest first and at most one per cycle.
- R6: The entries older than a probe are the held entries allocated before position probe_tail_i. The deciding entry is the youngest older entry whose address is either unknown or equal to probe_addr_i. probe_status_o is 0 when there is no deciding entry, and 2 (stall) when the deciding entry has a matching address but no data.
- R7: probe_status_o is 1 (forward) when the deciding entry has a matching address and data present, and probe_data_o then equals that entry's data.
- R8: probe_status_o is 3 (unknown dependence) when the deciding entry's address is not yet known, even if an older entry matches with data.
- R9: flush_i discards every held entry at position flush_ptr_i and younger. The next allocation position equals flush_ptr_i.
- R10: While flush_i is high, no store drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Request to allocate an entry in program order |
| alloc_ready_o | output | 1 | Allocation is accepted this cycle |
| alloc_ptr_o | output | IDX_W+1 | Position (phase bit and index) of the next allocation |
| addr_valid_i | input | 1 | Address write strobe |
| addr_idx_i | input | IDX_W | Entry index for the address write |
| addr_i | input | ADDR_W | Store granule address |
| data_valid_i | input | 1 | Data write strobe |
| data_idx_i | input | IDX_W | Entry index for the data write |
| data_i | input | DATA_W | Store data |
| probe_tail_i | input | IDX_W+1 | Allocation position recorded by the probing load |
| probe_addr_i | input | ADDR_W | Load granule address |
| probe_status_o | output | 2 | 0 none, 1 forward, 2 stall, 3 unknown dependence |
| probe_data_o | output | DATA_W | Forwarded data, zero unless status is 1 |
| drain_valid_o | output | 1 | Oldest store is complete and offered |
| drain_ready_i | input | 1 | Downstream accepts the offered store |
| drain_addr_o | output | ADDR_W | Address of the offered store |
| drain_data_o | output | DATA_W | Data of the offered store |
| flush_i | input | 1 | Discard entries from flush_ptr_i onward |
| flush_ptr_i | input | IDX_W+1 | First position to discard |

## Verification
The assertions assume that flush_ptr_i and probe_tail_i always name a position between the oldest held entry and the next allocation position, both ends included, and that each half of a held entry is written at most once. The checker's own occupancy count relies on the first of these. The stimulus draws both positions from that window every cycle. Its address and data writes go only to held entries that still lack the half being written. Addresses come from a pool of four values, so that matches, stalls and unknown dependences occur often.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    PRB_NONE  = 2'd0,
    PRB_FWD   = 2'd1,
    PRB_STALL = 2'd2,
    PRB_UNK   = 2'd3
  } prb_e;

  // distance from position (hp,hi) forward to (tp,ti) on a ring of depth entries
  function automatic logic [31:0] ring_dist(input logic hp, input logic [31:0] hi,
                                            input logic tp, input logic [31:0] ti,
                                            input logic [31:0] depth);
    if (hp == tp) return ti - hi;
    return ti + depth - hi;
  endfunction
endpackage

// File: rtl/sq_slot.sv
module sq_slot #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              kill_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic              addr_v_o,
  output logic              data_v_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      addr_v_o <= 1'b0;
      data_v_o <= 1'b0;
    end else if (alloc_i) begin
      valid_o  <= 1'b1;
      addr_v_o <= 1'b0;
      data_v_o <= 1'b0;
    end else if (kill_i) begin
      valid_o  <= 1'b0;
      addr_v_o <= 1'b0;
      data_v_o <= 1'b0;
    end else begin
      if (addr_we_i) addr_v_o <= 1'b1;
      if (data_we_i) data_v_o <= 1'b1;
    end
  end

  // payload needs no reset: qualified by the flags
  always_ff @(posedge clk_i) begin
    if (addr_we_i) addr_o <= addr_i;
    if (data_we_i) data_o <= data_i;
  end
endmodule

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
  parameter int DEPTH = 36,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_fire_i,
  input  logic             drain_fire_i,
  input  logic             flush_i,
  input  logic [PTR_W-1:0] flush_ptr_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o
);
  import sq_pkg::*;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    if (p[IDX_W-1:0] == IDX_W'(DEPTH - 1)) return {~p[PTR_W-1], {IDX_W{1'b0}}};
    return p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o <= '0;
      tail_o <= '0;
    end else begin
      if (flush_i)           tail_o <= flush_ptr_i;
      else if (alloc_fire_i) tail_o <= step(tail_o);
      if (drain_fire_i)      head_o <= step(head_o);
    end
  end

  always_comb
    count_o = CNT_W'(ring_dist(head_o[PTR_W-1], 32'(head_o[IDX_W-1:0]),
                               tail_o[PTR_W-1], 32'(tail_o[IDX_W-1:0]), 32'(DEPTH)));
endmodule

// File: rtl/sq_probe.sv
module sq_probe #(
  parameter int DEPTH  = 36,
  parameter int ADDR_W = 40,
  parameter int DATA_W = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]             valid_i,
  input  logic [DEPTH-1:0]             addr_v_i,
  input  logic [DEPTH-1:0]             data_v_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
  input  logic [DEPTH-1:0][DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]             head_idx_i,
  input  logic [CNT_W-1:0]             older_cnt_i,
  input  logic [ADDR_W-1:0]            probe_addr_i,
  output sq_pkg::prb_e                 status_o,
  output logic [DATA_W-1:0]            data_o
);
  import sq_pkg::*;

  logic             hit;
  logic [IDX_W-1:0] sel;

  // walk oldest to youngest within the older window; last candidate wins
  always_comb begin
    int p;
    logic [IDX_W-1:0] pi;
    hit = 1'b0;
    sel = '0;
    for (int k = 0; k < DEPTH; k++) begin
      p = int'(head_idx_i) + k;
      if (p >= DEPTH) p = p - DEPTH;
      pi = IDX_W'(p);
      if (k < int'(older_cnt_i) && valid_i[pi] &&
          (!addr_v_i[pi] || addr_i[pi] == probe_addr_i)) begin
        hit = 1'b1;
        sel = pi;
      end
    end
  end

  always_comb begin
    data_o = '0;
    if (!hit)              status_o = PRB_NONE;
    else if (!addr_v_i[sel]) status_o = PRB_UNK;
    else if (data_v_i[sel]) begin
      status_o = PRB_FWD;
      data_o   = data_i[sel];
    end else               status_o = PRB_STALL;
  end
endmodule

// File: rtl/store_split_queue.sv
module store_split_queue #(
  parameter int DEPTH  = 36,
  parameter int ADDR_W = 40,
  parameter int DATA_W = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  output logic              alloc_ready_o,
  output logic [PTR_W-1:0]  alloc_ptr_o,
  input  logic              addr_valid_i,
  input  logic [IDX_W-1:0]  addr_idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [IDX_W-1:0]  data_idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PTR_W-1:0]  probe_tail_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic [1:0]        probe_status_o,
  output logic [DATA_W-1:0] probe_data_o,
  output logic              drain_valid_o,
  input  logic              drain_ready_i,
  output logic [ADDR_W-1:0] drain_addr_o,
  output logic [DATA_W-1:0] drain_data_o,
  input  logic              flush_i,
  input  logic [PTR_W-1:0]  flush_ptr_i
);
  import sq_pkg::*;

  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count, keep_cnt, older_cnt;
  logic [IDX_W-1:0] head_idx;
  logic             alloc_fire, drain_fire;

  logic [DEPTH-1:0]             slot_v, slot_av, slot_dv;
  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
  logic [DEPTH-1:0][DATA_W-1:0] slot_data;
  prb_e                         prb_status;

  assign head_idx      = head[IDX_W-1:0];
  assign alloc_ready_o = (count < CNT_W'(DEPTH)) && !flush_i;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;
  assign alloc_ptr_o   = tail;
  assign drain_valid_o = !flush_i && slot_v[head_idx] && slot_av[head_idx] && slot_dv[head_idx];
  assign drain_fire    = drain_valid_o && drain_ready_i;
  assign drain_addr_o  = slot_addr[head_idx];
  assign drain_data_o  = slot_data[head_idx];

  always_comb begin
    keep_cnt  = CNT_W'(ring_dist(head[PTR_W-1], 32'(head_idx), flush_ptr_i[PTR_W-1],
                                 32'(flush_ptr_i[IDX_W-1:0]), 32'(DEPTH)));
    older_cnt = CNT_W'(ring_dist(head[PTR_W-1], 32'(head_idx), probe_tail_i[PTR_W-1],
                                 32'(probe_tail_i[IDX_W-1:0]), 32'(DEPTH)));
  end

  sq_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
    .clk_i, .rst_ni,
    .alloc_fire_i (alloc_fire),
    .drain_fire_i (drain_fire),
    .flush_i,
    .flush_ptr_i,
    .head_o       (head),
    .tail_o       (tail),
    .count_o      (count)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    int   rel;
    logic kill;
    always_comb begin
      rel  = (i >= int'(head_idx)) ? i - int'(head_idx) : i + DEPTH - int'(head_idx);
      kill = (flush_i && rel >= int'(keep_cnt)) || (drain_fire && head_idx == IDX_W'(i));
    end

    sq_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_slot (
      .clk_i, .rst_ni,
      .alloc_i   (alloc_fire && tail[IDX_W-1:0] == IDX_W'(i)),
      .kill_i    (kill),
      .addr_we_i (addr_valid_i && addr_idx_i == IDX_W'(i) && slot_v[i]),
      .addr_i    (addr_i),
      .data_we_i (data_valid_i && data_idx_i == IDX_W'(i) && slot_v[i]),
      .data_i    (data_i),
      .valid_o   (slot_v[i]),
      .addr_v_o  (slot_av[i]),
      .data_v_o  (slot_dv[i]),
      .addr_o    (slot_addr[i]),
      .data_o    (slot_data[i])
    );
  end

  sq_probe #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_probe (
    .valid_i      (slot_v),
    .addr_v_i     (slot_av),
    .data_v_i     (slot_dv),
    .addr_i       (slot_addr),
    .data_i       (slot_data),
    .head_idx_i   (head_idx),
    .older_cnt_i  (older_cnt),
    .probe_addr_i,
    .status_o     (prb_status),
    .data_o       (probe_data_o)
  );

  assign probe_status_o = prb_status;
endmodule

// File: rtl/sq_chk.sv
module sq_chk #(
  parameter int DEPTH = 36,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_valid_i,
  input logic             alloc_ready_o,
  input logic [PTR_W-1:0] alloc_ptr_o,
  input logic             drain_valid_o,
  input logic             drain_ready_i,
  input logic             flush_i,
  input logic [PTR_W-1:0] flush_ptr_i,
  input logic [1:0]       probe_status_o
);
  import sq_pkg::*;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    if (p[IDX_W-1:0] == IDX_W'(DEPTH - 1)) return {~p[PTR_W-1], {IDX_W{1'b0}}};
    return p + PTR_W'(1);
  endfunction

  // occupancy rebuilt from port traffic only
  logic [PTR_W-1:0] c_head;
  int               occ;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_head <= '0;
      occ    <= 0;
    end else begin
      if (drain_valid_o && drain_ready_i) c_head <= nxt(c_head);
      if (flush_i)
        occ <= int'(ring_dist(c_head[PTR_W-1], 32'(c_head[IDX_W-1:0]), flush_ptr_i[PTR_W-1],
                              32'(flush_ptr_i[IDX_W-1:0]), 32'(DEPTH)));
      else
        occ <= occ + int'(alloc_valid_i && alloc_ready_o) - int'(drain_valid_o && drain_ready_i);
    end
  end

  p_ready_has_room_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ready_o |-> occ < DEPTH);
  p_full_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ == DEPTH |-> !alloc_ready_o);
  p_alloc_ptr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_ready_o) |=> alloc_ptr_o == nxt($past(alloc_ptr_o)));
  p_flush_halts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!drain_valid_o && !alloc_ready_o));
  p_drain_needs_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_valid_o |-> occ > 0);
  p_drain_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_valid_o && !drain_ready_i && !flush_i) |=> (drain_valid_o || flush_i));
  p_empty_no_hazard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ == 0 |-> probe_status_o == 2'd0);
endmodule

bind store_split_queue sq_chk #(.DEPTH(DEPTH)) i_sq_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_ready_o  (alloc_ready_o),
  .alloc_ptr_o    (alloc_ptr_o),
  .drain_valid_o  (drain_valid_o),
  .drain_ready_i  (drain_ready_i),
  .flush_i        (flush_i),
  .flush_ptr_i    (flush_ptr_i),
  .probe_status_o (probe_status_o)
);

// File: tb/test_store_split_queue.sv
module test_store_split_queue;
  localparam int DEPTH  = 36;
  localparam int ADDR_W = 40;
  localparam int DATA_W = 128;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int PTR_W  = IDX_W + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic              alloc_valid, alloc_ready;
  logic [PTR_W-1:0]  alloc_ptr;
  logic              addr_valid, data_valid;
  logic [IDX_W-1:0]  addr_idx, data_idx;
  logic [ADDR_W-1:0] addr_in, probe_addr, drain_addr;
  logic [DATA_W-1:0] data_in, probe_data, drain_data;
  logic [PTR_W-1:0]  probe_tail, flush_ptr;
  logic [1:0]        probe_status;
  logic              drain_valid, drain_ready, flush;

  store_split_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store_split_queue (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid), .alloc_ready_o(alloc_ready), .alloc_ptr_o(alloc_ptr),
    .addr_valid_i(addr_valid), .addr_idx_i(addr_idx), .addr_i(addr_in),
    .data_valid_i(data_valid), .data_idx_i(data_idx), .data_i(data_in),
    .probe_tail_i(probe_tail), .probe_addr_i(probe_addr),
    .probe_status_o(probe_status), .probe_data_o(probe_data),
    .drain_valid_o(drain_valid), .drain_ready_i(drain_ready),
    .drain_addr_o(drain_addr), .drain_data_o(drain_data),
    .flush_i(flush), .flush_ptr_i(flush_ptr)
  );

  // reference model: stores numbered by allocation sequence, slot = seq % DEPTH
  int hseq, tseq, pseq, fseq;
  bit m_av [DEPTH];
  bit m_dv [DEPTH];
  logic [ADDR_W-1:0] m_a [DEPTH];
  logic [DATA_W-1:0] m_d [DEPTH];
  logic [ADDR_W-1:0] pool [4];
  int n_cmp, n_bad;
  bit done, last_flush;
  string t_alloc, t_drain, t_probe;

  function automatic logic [PTR_W-1:0] s2p(input int s);
    return {1'((s / DEPTH) % 2), IDX_W'(s % DEPTH)};
  endfunction

  function automatic int held_seq(input int idx);
    return hseq + ((idx - (hseq % DEPTH) + DEPTH) % DEPTH);
  endfunction

  task automatic chk(input string tag, input string what, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; addr_valid = 0; data_valid = 0; drain_ready = 0; flush = 0;
    addr_idx = '0; data_idx = '0; addr_in = '0; data_in = '0;
    probe_addr = '0; pseq = hseq; fseq = tseq;
  endtask

  task automatic tick();
    bit e_ready, e_dv, dfire, afire;
    int e_st, sel;
    string tg;
    probe_tail = s2p(pseq);
    flush_ptr  = s2p(fseq);
    #5;
    e_ready = (tseq - hseq < DEPTH) && !flush;
    chk(t_alloc, "alloc_ready", DATA_W'(alloc_ready), DATA_W'(e_ready));
    chk(last_flush ? "R9" : t_alloc, "alloc_ptr", DATA_W'(alloc_ptr), DATA_W'(s2p(tseq)));
    e_dv = (tseq > hseq) && m_av[hseq % DEPTH] && m_dv[hseq % DEPTH] && !flush;
    chk(flush ? "R10" : t_drain, "drain_valid", DATA_W'(drain_valid), DATA_W'(e_dv));
    if (e_dv) begin
      chk(t_drain, "drain_addr", DATA_W'(drain_addr), DATA_W'(m_a[hseq % DEPTH]));
      chk(t_drain, "drain_data", drain_data, m_d[hseq % DEPTH]);
    end
    sel = -1;
    for (int s = hseq; s < pseq; s++)
      if (!m_av[s % DEPTH] || m_a[s % DEPTH] == probe_addr) sel = s;
    if (sel < 0) e_st = 0;
    else if (!m_av[sel % DEPTH]) e_st = 3;
    else if (m_dv[sel % DEPTH]) e_st = 1;
    else e_st = 2;
    tg = (t_probe != "") ? t_probe : (e_st == 1) ? "R7" : (e_st == 3) ? "R8" : "R6";
    chk(tg, "probe_status", DATA_W'(probe_status), DATA_W'(e_st));
    if (e_st == 1) chk(tg, "probe_data", probe_data, m_d[sel % DEPTH]);
    dfire = e_dv && drain_ready;
    afire = e_ready && alloc_valid;
    @(posedge clk);
    if (addr_valid && held_seq(addr_idx) < tseq) begin
      m_av[addr_idx] = 1; m_a[addr_idx] = addr_in;
    end
    if (data_valid && held_seq(data_idx) < tseq) begin
      m_dv[data_idx] = 1; m_d[data_idx] = data_in;
    end
    if (dfire) hseq++;
    last_flush = flush;
    if (flush) tseq = fseq;
    else if (afire) begin
      m_av[tseq % DEPTH] = 0; m_dv[tseq % DEPTH] = 0; tseq++;
    end
    @(negedge clk);
  endtask

  task automatic wr_addr(input int s, input logic [ADDR_W-1:0] a);
    addr_valid = 1; addr_idx = IDX_W'(s % DEPTH); addr_in = a;
  endtask
  task automatic wr_data(input int s, input logic [DATA_W-1:0] d);
    data_valid = 1; data_idx = IDX_W'(s % DEPTH); data_in = d;
  endtask
  function automatic logic [DATA_W-1:0] rnd_data();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic probe(input int s, input logic [ADDR_W-1:0] a, input string tag);
    pseq = s; probe_addr = a; t_probe = tag; tick(); t_probe = ""; idle();
  endtask

  initial begin
    logic [DATA_W-1:0] d0, d1;
    pool[0] = 40'h00_1000_0010; pool[1] = 40'h00_1000_0020;
    pool[2] = 40'h7f_0000_0010; pool[3] = 40'h00_0000_0000;
    hseq = 0; tseq = 0; n_cmp = 0; n_bad = 0; done = 0; last_flush = 0;
    t_alloc = "R2"; t_drain = "R5"; t_probe = "";
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: empty after reset
    t_alloc = "R1"; t_drain = "R1"; t_probe = "R1";
    tick();
    t_alloc = "R2"; t_drain = "R5"; t_probe = "";

    // R2: three allocations
    for (int k = 0; k < 3; k++) begin alloc_valid = 1; tick(); end
    idle();
    wr_addr(1, pool[0]); tick(); idle();
    probe(3, pool[0], "R8");                 // seq2 address unknown, younger than match
    d0 = rnd_data(); d1 = rnd_data();
    wr_addr(2, pool[1]); wr_data(0, d0); tick(); idle();  // R4 same-cycle halves
    probe(3, pool[0], "R6");                 // seq1 matches, data missing: stall
    wr_data(1, d1); tick(); idle();
    probe(3, pool[0], "R7");                 // forward seq1
    wr_addr(0, pool[0]); tick(); idle();     // R4 data before address
    probe(1, pool[0], "R4");                 // seq0 complete now
    probe(3, pool[1], "R6");
    probe(2, pool[2], "R6");
    probe(0, pool[0], "R6");                 // no older stores
    drain_ready = 1; t_drain = "R5";
    repeat (3) tick();                       // two drain, seq2 blocked
    wr_data(2, rnd_data()); tick();
    tick(); tick();
    idle();

    // R3: fill to full and keep asking
    t_alloc = "R3";
    for (int k = 0; k < DEPTH + 3; k++) begin alloc_valid = 1; tick(); end
    idle();
    t_alloc = "R2";
    for (int s = hseq; s < tseq; s++) begin
      wr_addr(s, pool[s % 4]);
      if (s < hseq + 8) wr_data(s, rnd_data());
      pseq = tseq; probe_addr = pool[s % 3];
      tick(); idle();
    end
    // R10 and R9: flush with a drainable head
    flush = 1; fseq = hseq + 5; drain_ready = 1; alloc_valid = 1; tick(); idle();
    alloc_valid = 1; tick(); idle();
    probe(tseq, pool[2], "R9");

    // random traffic
    for (int c = 0; c < 6000; c++) begin
      int occ;
      idle();
      occ = tseq - hseq;
      alloc_valid = ($urandom_range(0, 2) != 0);
      drain_ready = ($urandom_range(0, 3) != 0);
      if (occ > 0 && $urandom_range(0, 1) == 1) begin
        int s = hseq + $urandom_range(0, occ - 1);
        if (!m_av[s % DEPTH]) wr_addr(s, pool[$urandom_range(0, 3)]);
      end
      if (occ > 0 && $urandom_range(0, 2) == 0) begin
        int s = hseq + $urandom_range(0, occ - 1);
        if (!m_dv[s % DEPTH]) wr_data(s, rnd_data());
      end
      if ($urandom_range(0, 49) == 0) begin
        flush = 1; fseq = hseq + $urandom_range(0, occ);
      end
      pseq = hseq + $urandom_range(0, occ);
      probe_addr = pool[$urandom_range(0, 3)];
      tick();
    end
    idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule